// File: doc/BRIEF.md
# Converter Control Word and Power-State Sequencer

This block keeps the 8-bit configuration word of a dual-channel current-output converter and turns it into plain operating-state levels. A controller presents a word on `cfg_word` and pulses `cfg_wr` for one clock. The block keeps the input-format, reference-select and gain fields of that word. It decodes a power state from the word, and power-down takes priority over every other field. Moving into normal operation from standby or from power-down starts a wake-up timer. Until the timer runs out, `active` and `ready` stay low.

The word port is a plain register write. It applies no back-pressure: every cycle with `cfg_wr` high is accepted, and a later write overrides an earlier one. The word layout is fixed because the controller that writes it relies on it. Bit 7 requests power-down. Bit 6 enables the converter. Bit 5 selects interleaved input. Bit 4 selects the external reference. Bits 3..0 carry the gain code, with bit 3 as its MSB. `WAKE_CYC` gives the wake-up interval in clock cycles. At 165 MHz a 3 µs interval is 495 cycles. `WAKE_CYC` must be at least 1.

Top module: `dacseq_top`

## Requirements
- R1: A word on `cfg_word` with `cfg_wr` high is captured at that rising edge, and its effects show on the outputs from the next cycle. With `cfg_wr` low, `ilv_en`, `iref_en` and `gain_code` keep their values.
- R2: If bit 7 of the written word is 1, the block enters power-down: `pwr_down`=1 and `standby`=`active`=`ready`=0, whatever bits 6..0 hold.
- R3: If bits 7 and 6 of the written word are both 0, the block enters standby: `standby`=1 and `pwr_down`=`active`=`ready`=0.
- R4: `ilv_en` follows bit 5 of the last written word (1 = interleaved input).
- R5: `iref_en` is the inverse of bit 4 of the last written word (bit 4 = 0 enables the internal reference).
- R6: `gain_code` equals bits 3..0 of the last written word, with bit 3 as the MSB.
- R7: While reset is held and after it is released, the outputs are: `pwr_down`=0, `standby`=0, `active`=`ready`=1, `ilv_en`=0, `iref_en`=1, `gain_code`=0. No wake-up interval runs.
- R8: A normal word (bit 7 = 0, bit 6 = 1) written while in standby or power-down holds `active` and `ready` low for exactly `WAKE_CYC` cycles after the write edge. Both rise on the following edge, without any further write.
- R9: A normal word written while already running keeps `ready` high with no wake-up gap.
- R10: A normal word written during a wake-up interval restarts the full `WAKE_CYC` interval from that write.
- R11: A power-down or standby word written during a wake-up interval cancels it at once. The new state shows in the next cycle, and `ready` stays low.
- R12: At most one of `pwr_down`, `standby` and `active` is high, and `active` always equals `ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe for `cfg_word` |
| cfg_word | input | 8 | Control word: [7] power-down, [6] enable, [5] interleave, [4] external reference, [3:0] gain |
| pwr_down | output | 1 | Power-down state |
| standby | output | 1 | Standby state |
| active | output | 1 | Converter in normal operation |
| ilv_en | output | 1 | Interleaved input selected |
| iref_en | output | 1 | Internal reference enabled |
| gain_code | output | 4 | Gain-adjust code |
| ready | output | 1 | Converter ready (wake-up complete) |

## Verification
The assertions check the following on every cycle:
- power-down wins over every other field, and the standby decode;
- the capture of the reference, interleave and gain fields, and that these fields hold while no write occurs;
- that the three state outputs are mutually exclusive;
- that a running converter never drops `ready` on a normal write;
- that `ready` rises only after a cycle count equal to `WAKE_CYC` since the last write.

The bench scenarios are needed to show the reset defaults, the exact restart of the interval when a second normal word arrives mid-wake, and the cancel by a standby or power-down word. They also cover wake-up from power-down as well as from standby, and long random mixes of writes measured against an independent model.

// File: rtl/dacseq_pkg.sv
package dacseq_pkg;
  localparam int GAIN_W = 4;
  localparam int WORD_W = 4 + GAIN_W;

  // Fields retained after a write (layout of the lower word bits)
  typedef struct packed {
    logic              ilv;
    logic              xref;
    logic [GAIN_W-1:0] gain;
  } set_t;

  // Full control word as written by the controller
  typedef struct packed {
    logic halt;
    logic run;
    set_t set;
  } cw_t;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_STBY = 2'd1,
    ST_WAKE = 2'd2,
    ST_RUN  = 2'd3
  } st_t;

  localparam set_t SET_RESET = '{ilv: 1'b0, xref: 1'b0, gain: '0};
endpackage

// File: rtl/dacseq_word_reg.sv
module dacseq_word_reg
  import dacseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  set_t din,
  output set_t q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= SET_RESET;
    else if (wr) q <= din;
  end
endmodule

// File: rtl/dacseq_wake_timer.sv
module dacseq_wake_timer #(
  parameter int WAKE_CYC = 495
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic done
);
  localparam int CW = (WAKE_CYC < 2) ? 1 : $clog2(WAKE_CYC);
  localparam logic [CW-1:0] START = CW'(WAKE_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= START;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/dacseq_mode_fsm.sv
module dacseq_mode_fsm
  import dacseq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr,
  input  logic req_halt,
  input  logic req_run,
  input  logic tmr_done,
  output logic tmr_load,
  output st_t  st
);
  st_t st_nx;

  // A normal word starts (or restarts) the timer unless already running
  assign tmr_load = wr && !req_halt && req_run && (st != ST_RUN);

  always_comb begin
    st_nx = st;
    if (wr) begin
      if (req_halt)      st_nx = ST_OFF;
      else if (!req_run) st_nx = ST_STBY;
      else if (st != ST_RUN) st_nx = ST_WAKE;
    end else if (st == ST_WAKE && tmr_done) begin
      st_nx = ST_RUN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st <= ST_RUN;
    else        st <= st_nx;
  end
endmodule

// File: rtl/dacseq_top.sv
module dacseq_top
  import dacseq_pkg::*;
#(
  parameter int WAKE_CYC = 495
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [WORD_W-1:0] cfg_word,
  output logic              pwr_down,
  output logic              standby,
  output logic              active,
  output logic              ilv_en,
  output logic              iref_en,
  output logic [GAIN_W-1:0] gain_code,
  output logic              ready
);
  cw_t  word_in;
  set_t set_q;
  st_t  st;
  logic tmr_load;
  logic tmr_done;

  assign word_in = cw_t'(cfg_word);

  dacseq_word_reg u_reg (
    .clk  (clk),
    .rst_n(rst_n),
    .wr   (cfg_wr),
    .din  (word_in.set),
    .q    (set_q)
  );

  dacseq_mode_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr      (cfg_wr),
    .req_halt(word_in.halt),
    .req_run (word_in.run),
    .tmr_done(tmr_done),
    .tmr_load(tmr_load),
    .st      (st)
  );

  dacseq_wake_timer #(.WAKE_CYC(WAKE_CYC)) u_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .load (tmr_load),
    .done (tmr_done)
  );

  assign pwr_down  = (st == ST_OFF);
  assign standby   = (st == ST_STBY);
  assign active    = (st == ST_RUN);
  assign ready     = (st == ST_RUN);
  assign ilv_en    = set_q.ilv;
  assign iref_en   = ~set_q.xref;
  assign gain_code = set_q.gain;
endmodule

// File: rtl/dacseq_chk.sv
module dacseq_chk #(
  parameter int WAKE_CYC = 495
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_wr,
  input logic [7:0] cfg_word,
  input logic       pwr_down,
  input logic       standby,
  input logic       active,
  input logic       ilv_en,
  input logic       iref_en,
  input logic [3:0] gain_code,
  input logic       ready
);
  logic [31:0] since_wr;

  always_ff @(posedge clk) begin
    if (!rst_n)       since_wr <= '0;
    else if (cfg_wr)  since_wr <= '0;
    else if (!ready && since_wr != 32'hFFFF_FFFF) since_wr <= since_wr + 1;
  end

  p_pd_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && cfg_word[7] |=> pwr_down && !standby && !ready);

  p_stby_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && !cfg_word[7] && !cfg_word[6] |=> standby && !pwr_down && !ready);

  p_ilv_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> ilv_en == $past(cfg_word[5]));

  p_iref_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> iref_en == !$past(cfg_word[4]));

  p_gain_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> gain_code == $past(cfg_word[3:0]));

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(gain_code) && $stable(ilv_en) && $stable(iref_en));

  p_wake_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> since_wr == 32'(WAKE_CYC));

  p_stay_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr && !cfg_word[7] && cfg_word[6] && ready |=> ready);

  p_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pwr_down, standby, active}) && (active == ready));
endmodule

bind dacseq_top dacseq_chk #(.WAKE_CYC(WAKE_CYC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_wr   (cfg_wr),
  .cfg_word (cfg_word),
  .pwr_down (pwr_down),
  .standby  (standby),
  .active   (active),
  .ilv_en   (ilv_en),
  .iref_en  (iref_en),
  .gain_code(gain_code),
  .ready    (ready)
);

// File: tb/sim_dacseq_top.sv
`timescale 1ns/100ps
module sim_dacseq_top;
  localparam int W = 12;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_word = 8'h00;
  logic       pwr_down, standby, active, ilv_en, iref_en, ready;
  logic [3:0] gain_code;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  dacseq_top #(.WAKE_CYC(W)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_word(cfg_word),
    .pwr_down(pwr_down), .standby(standby), .active(active),
    .ilv_en(ilv_en), .iref_en(iref_en), .gain_code(gain_code), .ready(ready)
  );

  // Reference model from the requirements: 0 off, 1 standby, 2 waking, 3 running
  int         m_st = 3;
  int         m_left = 0;
  logic [7:0] m_word = 8'h40;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st <= 3; m_left <= 0; m_word <= 8'h40;
    end else if (cfg_wr) begin
      m_word <= cfg_word;
      if (cfg_word[7])       m_st <= 0;
      else if (!cfg_word[6]) m_st <= 1;
      else if (m_st != 3) begin m_st <= 2; m_left <= W; end
    end else if (m_st == 2) begin
      m_left <= m_left - 1;
      if (m_left == 1) m_st <= 3;
    end
  end

  task automatic cmp1(string req, string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s (%s): actual %0d expected %0d at %0t", req, tag, act, exp, $time);
    end
  endtask

  task automatic check_all(string tag);
    cmp1("R2", tag, pwr_down, m_st == 0);
    cmp1("R3", tag, standby,  m_st == 1);
    cmp1("R8", tag, active,   m_st == 3);
    cmp1("R8", tag, ready,    m_st == 3);
    cmp1("R4", tag, ilv_en,   m_word[5]);
    cmp1("R5", tag, iref_en,  !m_word[4]);
    cmp1("R6", tag, gain_code, m_word[3:0]);
    cmp1("R12", tag, $countones({pwr_down, standby, active}) <= 1, 1);
  endtask

  // At a falling edge: check outputs, then drive the next cycle's inputs
  task automatic step(bit w, logic [7:0] d, string tag);
    @(negedge clk);
    check_all(tag);
    cfg_wr = w;
    cfg_word = d;
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(1'b0, 8'h00, tag);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 150000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int lowcnt;
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    // R7: defaults while in reset and right after release
    check_all("R7 in reset");
    rst_n = 1'b1;
    idle(3, "R7 after release");
    cmp1("R7", "ready default", ready, 1);
    cmp1("R7", "iref default", iref_en, 1);

    // R2: power-down with every other bit set
    step(1'b1, 8'hFF, "R2 write");
    idle(2, "R2 hold");
    cmp1("R2", "pd overrides enable", pwr_down, 1);
    // R11 path via R8: wake from power-down (R8, wake from off)
    step(1'b1, 8'h5A, "R8 wake from off");
    lowcnt = 0;
    for (int i = 0; i < 3 * W; i++) begin
      step(1'b0, 8'h00, "R8 counting");
      if (ready) break;
      lowcnt++;
    end
    cmp1("R8", "wake length from off", lowcnt, W);

    // R3: standby, then wake from standby
    step(1'b1, 8'h27, "R3 write");
    idle(2, "R3 hold");
    cmp1("R3", "standby level", standby, 1);
    step(1'b1, 8'h43, "R8 wake from stby");
    lowcnt = 0;
    for (int i = 0; i < 3 * W; i++) begin
      step(1'b0, 8'h00, "R8 counting");
      if (ready) break;
      lowcnt++;
    end
    cmp1("R8", "wake length from standby", lowcnt, W);

    // R9: normal write while running, no gap
    step(1'b1, 8'h7C, "R9 write");
    idle(2, "R9 hold");
    cmp1("R9", "ready kept", ready, 1);
    cmp1("R6", "gain field", gain_code, 4'hC);

    // R10: rewrite mid-wake restarts the interval
    step(1'b1, 8'h00, "R10 to standby");
    step(1'b1, 8'h41, "R10 first wake");
    idle(W / 2, "R10 mid");
    step(1'b1, 8'h42, "R10 rewrite");
    lowcnt = 0;
    for (int i = 0; i < 3 * W; i++) begin
      step(1'b0, 8'h00, "R10 counting");
      if (ready) break;
      lowcnt++;
    end
    cmp1("R10", "restart length", lowcnt, W);

    // R11: cancel mid-wake with standby, then with power-down
    step(1'b1, 8'h00, "R11 prep");
    step(1'b1, 8'h40, "R11 wake");
    idle(3, "R11 mid");
    step(1'b1, 8'h10, "R11 cancel stby");
    idle(W + 2, "R11 after stby cancel");
    cmp1("R11", "standby cancels", standby, 1);
    step(1'b1, 8'h40, "R11 wake again");
    idle(3, "R11 mid");
    step(1'b1, 8'h80, "R11 cancel pd");
    idle(W + 2, "R11 after pd cancel");
    cmp1("R11", "power-down cancels", pwr_down, 1);

    // R1: constrained random mix checked against the model every cycle
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      d[7] = ($urandom % 8) == 0;
      d[6] = ($urandom % 4) != 0;
      step(($urandom % 5) == 0, d, "R1 random");
    end
    idle(W + 2, "R1 drain");
    summary();
  end
endmodule